// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that a host controls through an eight-entry, byte-wide register window. The host first sets the target select line, the select mode, the frame width, the serial clock rate, the clock mode and the bit order. It then loads up to four data bytes. A write to the highest data byte launches the frame. The controller shifts the frame out on `mosi_o` and shifts the returned bits from `miso_i` into the same data bytes. The host polls a busy bit, or waits for the completion interrupt, and then reads the received bytes back.

The select lines can work in two ways. In automatic mode the chosen line goes low for the length of one frame and returns high after it. In manual mode the host holds the line low across any number of frames and releases it with a register write. The serial clock rate comes from the system clock through a divider. The parameter `SYS_MHZ` gives the system clock in MHz and must be a multiple of 16.

Top module: `spi_reg_master`

## Requirements
- R1: Bits [1:0] of register 1 set the frame width. The codes 00, 01, 10 and 11 give 8, 16, 24 and 32 bits. Exactly that many bits are shifted out and captured per frame.
- R2: Only a write to address 7 starts a frame. Writes to addresses 4, 5 and 6 load data and leave the block idle.
- R3: Bits [2:0] of register 0 pick one of eight active-low selects. In automatic mode (register 0 bit 6 clear), only that line is low, and only while a frame runs. All lines are high when the block is idle.
- R4: In manual mode (register 0 bit 6 set), bit 7 of register 0 drives the chosen line low. The line stays low across consecutive frames until bit 7 is cleared.
- R5: Address 4 holds the least significant byte and address 7 the most significant. After a frame, the received bits replace the frame's bits in these bytes. Bytes beyond the frame width keep their value.
- R6: Bit 0 of register 2 reads 1 from the start write until the frame is complete, and 0 otherwise.
- R7: Bits [3:2] of register 1 set the serial clock. The codes 0 to 3 give 1, 2, 4 and 8 MHz. Each half period of the serial clock lasts (SYS_MHZ/2) >> code system clocks.
- R8: Register 1 bit 4 (polarity) sets the idle clock level. Bit 5 (phase) clear means data are sampled on the leading edge. Bit 5 set means data are sampled on the trailing edge. All four modes transfer correctly.
- R9: Register 1 bit 6 set sends the frame and fills it least significant bit first. Clear means most significant bit first.
- R10: Bit 1 of register 2 is set when a frame completes. Any write to register 2 clears it. `irq_o` is this bit gated by register 1 bit 7, which resets to 0.
- R11: While a frame runs, writes to addresses 0, 1 and 4 to 7 have no effect on the select outputs, the configuration or the data.
- R12: After reset, all selects are high, `sclk_o` is low, and registers 0, 1 and 2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Completion interrupt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 8 | Active-low slave selects |

## Verification
The bench runs a slave model that follows the programmed clock mode. It compares every captured MOSI frame against the expected word, and every received word against the bytes read back.

It covers the following corner cases:
- All four frame widths. A width decoder that is off by one byte would garble the upper bytes, which must stay untouched.
- All four phase and polarity combinations. A design that samples on the wrong edge would return a word shifted by one bit.
- LSB-first order at an odd byte count. Wrong handling would place the received bits at the wrong end of the word.
- Back-to-back manual frames. A design that drops the select between frames would be caught.
- Configuration and data writes in the middle of a frame. A design that accepts them would corrupt the result or switch the width part way through.
- The half period measured at each rate. A wrong divider would show up as the wrong count.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int SYS_MHZ = 16,
  parameter int NSS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  output logic [7:0] bus_rdata,
  output logic       irq_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic [7:0] ss_n_o
);
  localparam int HALF0 = SYS_MHZ / 2;
  localparam int DIV_W = $clog2(HALF0 + 1);
  localparam int SEL_W = $clog2(NSS);

  logic [SEL_W-1:0] sel_q;
  logic             man_q, man_on_q;
  logic [1:0]       len_q, rate_q;
  logic             cpol_q, cpha_q, lsb_q, ien_q;
  logic             busy, done_q, tail_q, sclk_t, rx_q;
  logic [DIV_W-1:0] div_q;
  logic [6:0]       ecnt_q;
  logic [31:0]      shreg;

  logic [5:0]       nbits;
  logic [31:0]      mask, shifted;
  logic [DIV_W-1:0] half_lim;
  logic             tick, lead, sample_ev, shift_ev, last_edge, idle_wr;

  assign nbits     = {1'b0, len_q, 3'b000} + 6'd8;
  assign mask      = (len_q == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 32'd1);
  assign half_lim  = DIV_W'(HALF0 >> rate_q);
  assign tick      = busy && (div_q == half_lim - DIV_W'(1));
  assign lead      = ~ecnt_q[0];
  assign last_edge = (ecnt_q == {nbits, 1'b0} - 7'd1);
  assign sample_ev = tick && !tail_q && (lead ^ cpha_q);
  assign shift_ev  = tick && ((!tail_q && !(lead ^ cpha_q) && !(cpha_q && ecnt_q == 7'd0))
                             || (tail_q && cpha_q));
  assign idle_wr   = bus_we && !busy;

  always_comb begin
    if (lsb_q)
      shifted = (shreg & ~mask) | ((shreg >> 1) & (mask >> 1)) | ({31'd0, rx_q} << (nbits - 6'd1));
    else
      shifted = (shreg & ~mask) | ({shreg[30:0], rx_q} & mask);
  end

  assign mosi_o = lsb_q ? shreg[0] : shreg[5'(nbits - 6'd1)];
  assign sclk_o = sclk_t ^ cpol_q;
  assign irq_o  = done_q & ien_q;

  always_comb begin
    ss_n_o = '1;
    if ((man_q && man_on_q) || (!man_q && busy))
      ss_n_o[sel_q] = 1'b0;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {man_on_q, man_q, 6'(sel_q)};
      3'd1:    bus_rdata = {ien_q, lsb_q, cpha_q, cpol_q, rate_q, len_q};
      3'd2:    bus_rdata = {6'd0, done_q, busy};
      3'd4:    bus_rdata = shreg[7:0];
      3'd5:    bus_rdata = shreg[15:8];
      3'd6:    bus_rdata = shreg[23:16];
      3'd7:    bus_rdata = shreg[31:24];
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; man_q <= 1'b0; man_on_q <= 1'b0;
      len_q <= '0; rate_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      lsb_q <= 1'b0; ien_q <= 1'b0;
      busy <= 1'b0; done_q <= 1'b0; tail_q <= 1'b0; sclk_t <= 1'b0; rx_q <= 1'b0;
      div_q <= '0; ecnt_q <= '0; shreg <= '0;
    end else begin
      if (idle_wr) begin
        case (bus_addr)
          3'd0: begin
            sel_q    <= bus_wdata[SEL_W-1:0];
            man_q    <= bus_wdata[6];
            man_on_q <= bus_wdata[7];
          end
          3'd1: begin
            len_q  <= bus_wdata[1:0];
            rate_q <= bus_wdata[3:2];
            cpol_q <= bus_wdata[4];
            cpha_q <= bus_wdata[5];
            lsb_q  <= bus_wdata[6];
            ien_q  <= bus_wdata[7];
          end
          3'd4: shreg[7:0]   <= bus_wdata;
          3'd5: shreg[15:8]  <= bus_wdata;
          3'd6: shreg[23:16] <= bus_wdata;
          3'd7: begin
            shreg[31:24] <= bus_wdata;
            busy   <= 1'b1;
            done_q <= 1'b0;
            div_q  <= '0;
            ecnt_q <= '0;
            tail_q <= 1'b0;
            sclk_t <= 1'b0;
          end
          default: ;
        endcase
      end
      if (bus_we && bus_addr == 3'd2)
        done_q <= 1'b0;
      if (busy) begin
        div_q <= tick ? '0 : div_q + DIV_W'(1);
        if (sample_ev)
          rx_q <= miso_i;
        if (shift_ev)
          shreg <= shifted;
        if (tick && !tail_q) begin
          sclk_t <= ~sclk_t;
          ecnt_q <= ecnt_q + 7'd1;
          if (last_edge)
            tail_q <= 1'b1;
        end
        if (tick && tail_q) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_we,
  input logic       sclk_o,
  input logic [7:0] ss_n_o,
  input logic       irq_o,
  input logic       busy,
  input logic       man_q,
  input logic       cpol_q,
  input logic       ien_q,
  input logic [1:0] len_q
);
  // R3
  auto_idle_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_q && !busy) |-> (ss_n_o == 8'hFF));
  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n_o) <= 1);
  // R2
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && bus_addr == 3'd7));
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o == cpol_q));
  // R10
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($fell(busy) || $rose(ien_q)));
  // R11
  width_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .sclk_o(sclk_o), .ss_n_o(ss_n_o), .irq_o(irq_o), .busy(busy),
  .man_q(man_q), .cpol_q(cpol_q), .ien_q(ien_q), .len_q(len_q)
);

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic irq_o, sclk_o, mosi_o;
  logic miso_i = 1'b0;
  logic [7:0] ss_n_o;

  int errors = 0, checks = 0;
  int n_m = 8;
  logic cpol_m = 0, cpha_m = 0, lsb_m = 0;
  logic [31:0] slave_word = '0, cap = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  int k = 0, cyc = 0, last_tog = 0, half_meas = 0;
  logic sclk_prev = 1'b0;
  logic [31:0] cur_tx, cur_rx;

  always #4 clk = ~clk;

  spi_reg_master #(.SYS_MHZ(16), .NSS(8)) i_spi_reg_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pos(input int idx);
    return lsb_m ? idx : n_m - 1 - idx;
  endfunction

  function automatic logic [31:0] wmask();
    return (n_m == 32) ? 32'hFFFF_FFFF : ((32'd1 << n_m) - 32'd1);
  endfunction

  // slave model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (ss_n_o != 8'hFF && sclk_o != sclk_prev) begin
      half_meas = cyc - last_tog;
      last_tog = cyc;
      if (sclk_o != cpol_m) begin
        if (cpha_m) miso_i = slave_word[pos(k)];
        else cap[pos(k)] = mosi_o;
      end else begin
        if (cpha_m) cap[pos(k)] = mosi_o;
        k++;
        if (!cpha_m && k < n_m) miso_i = slave_word[pos(k)];
        if (k == n_m) begin
          if (exp_q.size() == 0) chk(1'b0, "R1 unexpected frame", cap, 32'h0);
          else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(cap == e, t, cap, e);
          end
          k = 0;
          cap = '0;
        end
      end
    end
    sclk_prev = sclk_o;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic fmt(input int len, input int rate, input logic cp, input logic ph, input logic lsb, input logic ie);
    wr(3'd1, {ie, lsb, ph, cp, 2'(rate), 2'(len)});
    n_m = 8 * (len + 1); cpol_m = cp; cpha_m = ph; lsb_m = lsb;
  endtask

  task automatic xstart(input logic [31:0] tx, input logic [31:0] rx, input string tag);
    logic [7:0] s;
    cur_tx = tx; cur_rx = rx;
    slave_word = rx;
    exp_q.push_back(tx & wmask());
    tag_q.push_back(tag);
    k = 0; cap = '0;
    if (!cpha_m) miso_i = rx[pos(0)];
    wr(3'd4, tx[7:0]); wr(3'd5, tx[15:8]); wr(3'd6, tx[23:16]);
    rd(3'd2, s);
    chk(s[0] == 1'b0, "R2 no start before top byte", 32'(s), 32'h0);
    wr(3'd7, tx[31:24]);
    rd(3'd2, s);
    chk(s[0] == 1'b1, "R6 busy after start", 32'(s), 32'h1);
  endtask

  task automatic xend(input string tag, input logic auto_ss);
    logic [7:0] s, b0, b1, b2, b3;
    logic [31:0] got, e;
    int n = 0;
    s = 8'h1;
    while (s[0] && n < 5000) begin rd(3'd2, s); n++; end
    chk(s[0] == 1'b0, "R6 busy clears", 32'(s), 32'h0);
    rd(3'd4, b0); rd(3'd5, b1); rd(3'd6, b2); rd(3'd7, b3);
    got = {b3, b2, b1, b0};
    e = (cur_rx & wmask()) | (cur_tx & ~wmask());
    chk(got == e, tag, got, e);
    chk(exp_q.size() == 0, "R1 frame observed", 32'(exp_q.size()), 32'h0);
    if (auto_ss) chk(ss_n_o == 8'hFF, "R3 selects released", 32'(ss_n_o), 32'hFF);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(ss_n_o == 8'hFF, "R12 selects", 32'(ss_n_o), 32'hFF);
    chk(sclk_o == 1'b0, "R12 sclk", 32'(sclk_o), 32'h0);
    rd(3'd0, v); chk(v == 8'h00, "R12 reg0", 32'(v), 32'h0);
    rd(3'd1, v); chk(v == 8'h00, "R12 reg1", 32'(v), 32'h0);
    rd(3'd2, v); chk(v == 8'h00, "R12 reg2", 32'(v), 32'h0);
    chk(irq_o == 1'b0, "R10 irq off at reset", 32'(irq_o), 32'h0);

    // R1 / R5 all widths, mode 0, MSB first
    fmt(0, 3, 0, 0, 0, 0);
    chk(sclk_o == 1'b0, "R8 idle low", 32'(sclk_o), 32'h0);
    xstart(32'hA1B2C3D4, 32'h5E6F7081, "R1 8-bit");
    chk(ss_n_o == 8'hFE, "R3 auto select line 0", 32'(ss_n_o), 32'hFE);
    xend("R1 8-bit readback", 1);
    fmt(1, 3, 0, 0, 0, 0); xstart(32'h1234ABCD, 32'hC0FFEE42, "R5 16-bit"); xend("R5 16-bit readback", 1);
    fmt(2, 3, 0, 0, 0, 0); xstart(32'h99887766, 32'h13579BDF, "R1 24-bit"); xend("R1 24-bit readback", 1);
    fmt(3, 3, 0, 0, 0, 0); xstart(32'hDEADBEEF, 32'h0F1E2D3C, "R5 32-bit"); xend("R5 32-bit readback", 1);

    // R8 other clock modes
    fmt(1, 3, 1, 0, 0, 0);
    chk(sclk_o == 1'b1, "R8 idle high", 32'(sclk_o), 32'h1);
    xstart(32'h0000A55A, 32'h00003CC3, "R8 mode2"); xend("R8 mode2 readback", 1);
    fmt(1, 2, 0, 1, 0, 0); xstart(32'h0000F00F, 32'h00008001, "R8 mode1"); xend("R8 mode1 readback", 1);
    fmt(1, 1, 1, 1, 0, 0); xstart(32'h00006E2B, 32'h0000B491, "R8 mode3"); xend("R8 mode3 readback", 1);

    // R9 LSB first
    fmt(2, 2, 0, 0, 1, 0); xstart(32'h00C31A07, 32'h0081F0E5, "R9 lsb 24"); xend("R9 lsb readback", 1);
    fmt(3, 3, 1, 1, 1, 0); xstart(32'h80000001, 32'h7FFE0102, "R9 lsb mode3"); xend("R9 lsb mode3 readback", 1);

    // R7 rates
    for (int r = 0; r < 4; r++) begin
      fmt(0, r, 0, 0, 0, 0);
      xstart(32'h000000B7, 32'h0000004C, "R7 rate frame");
      xend("R7 rate readback", 1);
      chk(half_meas == (8 >> r), "R7 half period", 32'(half_meas), 32'(8 >> r));
    end

    // R3 select line 7
    wr(3'd0, 8'h07);
    fmt(0, 3, 0, 0, 0, 0);
    xstart(32'h0000005A, 32'h000000A5, "R3 line7 frame");
    chk(ss_n_o == 8'h7F, "R3 line 7 low", 32'(ss_n_o), 32'h7F);
    xend("R3 line7 readback", 1);

    // R4 manual select across frames
    wr(3'd0, 8'hC3);
    chk(ss_n_o == 8'hF7, "R4 manual assert", 32'(ss_n_o), 32'hF7);
    xstart(32'h00000011, 32'h000000EE, "R4 frame a"); xend("R4 frame a readback", 0);
    chk(ss_n_o == 8'hF7, "R4 held between frames", 32'(ss_n_o), 32'hF7);
    xstart(32'h00000022, 32'h000000DD, "R4 frame b"); xend("R4 frame b readback", 0);
    chk(ss_n_o == 8'hF7, "R4 held after frames", 32'(ss_n_o), 32'hF7);
    wr(3'd0, 8'h43);
    chk(ss_n_o == 8'hFF, "R4 manual release", 32'(ss_n_o), 32'hFF);
    wr(3'd0, 8'h00);

    // R10 interrupt
    chk(irq_o == 1'b0, "R10 irq gated off", 32'(irq_o), 32'h0);
    wr(3'd2, 8'h00);
    fmt(0, 3, 0, 0, 0, 1);
    chk(irq_o == 1'b0, "R10 no irq before frame", 32'(irq_o), 32'h0);
    xstart(32'h00000033, 32'h000000CC, "R10 frame"); xend("R10 readback", 1);
    chk(irq_o == 1'b1, "R10 irq raised", 32'(irq_o), 32'h1);
    rd(3'd2, v); chk(v == 8'h02, "R10 done flag", 32'(v), 32'h02);
    wr(3'd2, 8'h00);
    chk(irq_o == 1'b0, "R10 irq cleared", 32'(irq_o), 32'h0);

    // R11 writes during a frame
    fmt(0, 0, 0, 0, 0, 0);
    xstart(32'h00000069, 32'h00000096, "R11 frame");
    wr(3'd4, 8'hEE); wr(3'd1, 8'hFF); wr(3'd0, 8'hC5);
    chk(ss_n_o == 8'hFE, "R11 select unchanged", 32'(ss_n_o), 32'hFE);
    xend("R11 data unchanged", 1);
    rd(3'd1, v); chk(v == 8'h00, "R11 format unchanged", 32'(v), 32'h0);
    rd(3'd0, v); chk(v == 8'h00, "R11 select reg unchanged", 32'(v), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule